// File: doc/BRIEF.md
# Real-Mode Code Segment Fetch Address Generator

This block holds the code segment state of a 32-bit processor running in real-address mode and produces the linear address of the next instruction fetch. The state has three parts: a visible 16-bit segment selector, a hidden 32-bit base and a 32-bit instruction pointer. The fetch address is the hidden base plus the instruction pointer. It is registered, so it appears one cycle after the state changes.

Normally the hidden base is the selector shifted left by four bits, which places it in the low megabyte. A synchronous reset is the exception. It loads the selector with 16'hF000, the hidden base with 32'hFFFF0000 and the instruction pointer with 32'h0000FFF0, so the first fetch comes from 32'hFFFFFFF0, near the top of the 32-bit space. No selector value can produce this base through the shift rule.

The elevated base survives sequential advance and near jumps. The first far jump or interrupt entry reloads the selector. From then on the block follows the ordinary shift rule until the next reset. A status output shows whether the elevated reset base is still in force.

Top module: `cs_fetch_addr_gen`

## Requirements
- R1: After a cycle with `rst` high, `fetch_addr` equals 32'hFFFFFFF0 and `boot_base_active` is 1. These values correspond to selector 16'hF000, hidden base 32'hFFFF0000 and instruction pointer 32'h0000FFF0.
- R2: `fetch_addr` equals (hidden base + instruction pointer) mod 2^32, and `boot_base_active` tracks the internal status bit. Both outputs are registered and show the state produced by a command one clock edge after that state is written, which is two rising edges after the command is sampled.
- R3: A near jump (`near_en`) sets the instruction pointer to `near_off` zero-extended to 32 bits. It leaves the selector and the hidden base unchanged, including the elevated reset base.
- R4: A far jump (`far_en`) loads the selector from `far_sel`, sets the hidden base to `far_sel` shifted left by 4 and zero-extended, and sets the instruction pointer to `far_off` zero-extended.
- R5: Interrupt entry (`int_en`) behaves as R4, using the vector-supplied `int_sel` and `int_off`.
- R6: `boot_base_active` stays 1 from reset until the first far jump or interrupt entry takes effect. After that it stays 0 until the next reset.
- R7: Sequential advance (`adv_en`) adds `adv_len` to the instruction pointer. While the elevated base is active the add is a full 32-bit add. Otherwise the low 16 bits wrap and the upper 16 bits stay 0.
- R8: When several controls are high in one cycle, only the highest takes effect. The order from highest to lowest is `rst`, `int_en`, `far_en`, `near_en`, `adv_en`.
- R9: In a cycle with no control high, the state and therefore `fetch_addr` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_en | input | 1 | Sequential advance request |
| adv_len | input | 4 | Instruction length to add |
| near_en | input | 1 | Near jump request |
| near_off | input | 16 | Near jump target offset |
| far_en | input | 1 | Far jump request |
| far_sel | input | 16 | Far jump selector |
| far_off | input | 16 | Far jump offset |
| int_en | input | 1 | Interrupt entry request |
| int_sel | input | 16 | Selector read from the vector table |
| int_off | input | 16 | Offset read from the vector table |
| fetch_addr | output | 32 | Registered linear fetch address |
| boot_base_active | output | 1 | Elevated reset base still in force |

## Verification
The assertions check several properties on every cycle. Once the elevated base is gone, the hidden base always equals the shifted selector and the upper half of the instruction pointer stays zero. The status bit never returns to 1 without a reset. A near jump leaves the base alone. The registered output always reflects the previous cycle's base plus pointer. Only the bench's scenarios show the following: exact fetch values across the 32-bit carry during the reset window, the 16-bit wrap after a reload, and the priority outcome for every combination of simultaneous requests. These scenarios compare the outputs against a separately computed model.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE = 3'd0,
    CMD_ADV  = 3'd1,
    CMD_NEAR = 3'd2,
    CMD_FAR  = 3'd3,
    CMD_INT  = 3'd4
  } cs_cmd_e;
endpackage

// File: rtl/cs_cmd_arb.sv
module cs_cmd_arb
  import cs_pkg::*;
#(
  parameter int SEL_W = 16,
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_en,
  input  logic             near_en,
  input  logic [OFF_W-1:0] near_off,
  input  logic             far_en,
  input  logic [SEL_W-1:0] far_sel,
  input  logic [OFF_W-1:0] far_off,
  input  logic             int_en,
  input  logic [SEL_W-1:0] int_sel,
  input  logic [OFF_W-1:0] int_off,
  output cs_cmd_e          cmd,
  output logic [SEL_W-1:0] sel_o,
  output logic [OFF_W-1:0] off_o
);
  // Fixed priority: interrupt, far, near, advance
  always_comb begin
    cmd   = CMD_IDLE;
    sel_o = '0;
    off_o = '0;
    if (int_en) begin
      cmd   = CMD_INT;
      sel_o = int_sel;
      off_o = int_off;
    end else if (far_en) begin
      cmd   = CMD_FAR;
      sel_o = far_sel;
      off_o = far_off;
    end else if (near_en) begin
      cmd   = CMD_NEAR;
      off_o = near_off;
    end else if (adv_en) begin
      cmd   = CMD_ADV;
    end
  end

  // R8: interrupt entry outranks every other request
  p_int_first_r8: assert property (@(posedge clk) disable iff (rst)
    int_en |-> (cmd == CMD_INT && sel_o == int_sel));
  // R8: advance only acts when nothing higher is requested
  p_adv_last_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_ADV) |-> !(int_en || far_en || near_en));
endmodule

// File: rtl/cs_seg_state.sv
module cs_seg_state
  import cs_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          SEL_W      = 16,
  parameter int          SHIFT      = 4,
  parameter logic [15:0] RESET_SEL  = 16'hF000,
  parameter logic [31:0] RESET_BASE = 32'hFFFF0000
) (
  input  logic              clk,
  input  logic              rst,
  input  cs_cmd_e           cmd,
  input  logic [SEL_W-1:0]  sel_in,
  output logic [SEL_W-1:0]  sel_q,
  output logic [ADDR_W-1:0] base_q,
  output logic              boot_q
);
  localparam int REAL_W = SEL_W + SHIFT;

  logic             load;
  logic [REAL_W-1:0] shifted;
  logic [ADDR_W-1:0] base_next;

  assign load    = (cmd == CMD_FAR) || (cmd == CMD_INT);
  assign shifted = {sel_in, {SHIFT{1'b0}}};

  generate
    if (ADDR_W > REAL_W) begin : g_ext
      assign base_next = {{(ADDR_W-REAL_W){1'b0}}, shifted};
    end else begin : g_trunc
      assign base_next = shifted[ADDR_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= RESET_SEL[SEL_W-1:0];
      base_q <= RESET_BASE[ADDR_W-1:0];
      boot_q <= 1'b1;
    end else if (load) begin
      sel_q  <= sel_in;
      base_q <= base_next;
      boot_q <= 1'b0;
    end
  end

  // R4/R5: after any reload the base obeys the shift rule
  p_base_from_sel_r4: assert property (@(posedge clk) disable iff (rst)
    !boot_q |-> (base_q[REAL_W-1:0] == {sel_q, {SHIFT{1'b0}}}));
  // R6: the elevated window never reopens without reset
  p_boot_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    !boot_q |=> !boot_q);
  // R3: near jump leaves the hidden base untouched
  p_near_keeps_base_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_NEAR) |=> $stable(base_q));
  // R5: interrupt reload takes the vector selector
  p_int_sel_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_INT) |=> (sel_q == $past(sel_in) && !boot_q));
endmodule

// File: rtl/cs_ip_state.sv
module cs_ip_state
  import cs_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          OFF_W    = 16,
  parameter int          LEN_W    = 4,
  parameter logic [31:0] RESET_IP = 32'h0000FFF0
) (
  input  logic              clk,
  input  logic              rst,
  input  cs_cmd_e           cmd,
  input  logic              boot,
  input  logic [OFF_W-1:0]  off_in,
  input  logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] ip_q
);
  localparam int HI_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] adv_full;
  logic [OFF_W-1:0]  adv_low;
  logic [ADDR_W-1:0] ip_next;

  assign off_ext  = {{HI_W{1'b0}}, off_in};
  assign adv_full = ip_q + {{(ADDR_W-LEN_W){1'b0}}, len};
  assign adv_low  = ip_q[OFF_W-1:0] + {{(OFF_W-LEN_W){1'b0}}, len};

  always_comb begin
    ip_next = ip_q;
    unique case (cmd)
      CMD_INT, CMD_FAR, CMD_NEAR: ip_next = off_ext;
      CMD_ADV:  ip_next = boot ? adv_full : {{HI_W{1'b0}}, adv_low};
      default:  ip_next = ip_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ip_q <= RESET_IP[ADDR_W-1:0];
    else     ip_q <= ip_next;
  end

  // R7: outside the reset window the pointer stays within 16 bits
  p_wrap16_r7: assert property (@(posedge clk) disable iff (rst)
    !boot |-> (ip_q[ADDR_W-1:OFF_W] == '0));
  // R9: idle cycles hold the pointer
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_IDLE) |=> $stable(ip_q));
endmodule

// File: rtl/cs_fetch_addr_gen.sv
module cs_fetch_addr_gen
  import cs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_en,
  input  logic [LEN_W-1:0]  adv_len,
  input  logic              near_en,
  input  logic [OFF_W-1:0]  near_off,
  input  logic              far_en,
  input  logic [SEL_W-1:0]  far_sel,
  input  logic [OFF_W-1:0]  far_off,
  input  logic              int_en,
  input  logic [SEL_W-1:0]  int_sel,
  input  logic [OFF_W-1:0]  int_off,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              boot_base_active
);
  localparam logic [15:0] RESET_SEL  = 16'hF000;
  localparam logic [31:0] RESET_BASE = 32'hFFFF0000;
  localparam logic [31:0] RESET_IP   = 32'h0000FFF0;
  localparam logic [ADDR_W-1:0] RESET_FETCH =
    RESET_BASE[ADDR_W-1:0] + RESET_IP[ADDR_W-1:0];

  cs_cmd_e           cmd;
  logic [SEL_W-1:0]  sel_pick;
  logic [OFF_W-1:0]  off_pick;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] base_q;
  logic              boot_q;
  logic [ADDR_W-1:0] ip_q;
  logic [ADDR_W-1:0] sum;
  logic              track_q;

  cs_cmd_arb #(.SEL_W(SEL_W), .OFF_W(OFF_W)) u_arb (
    .clk(clk), .rst(rst),
    .adv_en(adv_en), .near_en(near_en), .near_off(near_off),
    .far_en(far_en), .far_sel(far_sel), .far_off(far_off),
    .int_en(int_en), .int_sel(int_sel), .int_off(int_off),
    .cmd(cmd), .sel_o(sel_pick), .off_o(off_pick)
  );

  cs_seg_state #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .SHIFT(SHIFT),
    .RESET_SEL(RESET_SEL), .RESET_BASE(RESET_BASE)
  ) u_seg (
    .clk(clk), .rst(rst), .cmd(cmd), .sel_in(sel_pick),
    .sel_q(sel_q), .base_q(base_q), .boot_q(boot_q)
  );

  cs_ip_state #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LEN_W(LEN_W), .RESET_IP(RESET_IP)
  ) u_ip (
    .clk(clk), .rst(rst), .cmd(cmd), .boot(boot_q),
    .off_in(off_pick), .len(adv_len), .ip_q(ip_q)
  );

  assign sum = base_q + ip_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_addr       <= RESET_FETCH;
      boot_base_active <= 1'b1;
      track_q          <= 1'b0;
    end else begin
      fetch_addr       <= sum;
      boot_base_active <= boot_q;
      track_q          <= 1'b1;
    end
  end

  // R1: reset produces the top-of-space fetch vector
  p_reset_vec_r1: assert property (@(posedge clk)
    rst |=> (fetch_addr == RESET_FETCH && boot_base_active));
  // R2: output reflects previous cycle's base plus pointer
  p_fetch_tracks_r2: assert property (@(posedge clk) disable iff (rst)
    track_q |-> (fetch_addr == $past(sum) && boot_base_active == $past(boot_q)));
  // R4: selector register is only observable through the base
  p_sel_consistent_r4: assert property (@(posedge clk) disable iff (rst)
    boot_q |-> (sel_q == RESET_SEL[SEL_W-1:0]));
endmodule

// File: tb/tb_cs_fetch_addr_gen.sv
`timescale 1ns/1ps
module tb_cs_fetch_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv_en = 0, near_en = 0, far_en = 0, int_en = 0;
  logic [3:0]  adv_len = '0;
  logic [15:0] near_off = '0, far_sel = '0, far_off = '0, int_sel = '0, int_off = '0;
  logic [31:0] fetch_addr;
  logic        boot_base_active;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [15:0] m_sel;
  logic [31:0] m_base, m_ip;
  logic        m_boot;

  always #2.5 clk = ~clk;

  cs_fetch_addr_gen dut (
    .clk(clk), .rst(rst),
    .adv_en(adv_en), .adv_len(adv_len),
    .near_en(near_en), .near_off(near_off),
    .far_en(far_en), .far_sel(far_sel), .far_off(far_off),
    .int_en(int_en), .int_sel(int_sel), .int_off(int_off),
    .fetch_addr(fetch_addr), .boot_base_active(boot_base_active)
  );

  task automatic check(string req);
    logic [31:0] exp_a;
    exp_a = m_base + m_ip;
    checks++;
    if (fetch_addr !== exp_a || boot_base_active !== m_boot) begin
      errors++;
      $display("FAIL %s: fetch_addr=%h status=%b expected %h status=%b",
               req, fetch_addr, boot_base_active, exp_a, m_boot);
    end
  endtask

  task automatic do_reset(string req);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_sel = 16'hF000; m_base = 32'hFFFF0000; m_ip = 32'h0000FFF0; m_boot = 1'b1;
    check(req);
  endtask

  // apply one cycle of controls, update the model, check two edges later
  task automatic step(input bit a, input logic [3:0] l,
                      input bit n, input logic [15:0] no,
                      input bit f, input logic [15:0] fs, input logic [15:0] fo,
                      input bit i, input logic [15:0] is_, input logic [15:0] io,
                      input string req);
    logic [15:0] low;
    @(negedge clk);
    adv_en = a; adv_len = l; near_en = n; near_off = no;
    far_en = f; far_sel = fs; far_off = fo;
    int_en = i; int_sel = is_; int_off = io;
    if (i) begin
      m_sel = is_; m_base = {12'h0, is_, 4'h0}; m_ip = {16'h0, io}; m_boot = 1'b0;
    end else if (f) begin
      m_sel = fs; m_base = {12'h0, fs, 4'h0}; m_ip = {16'h0, fo}; m_boot = 1'b0;
    end else if (n) begin
      m_ip = {16'h0, no};
    end else if (a) begin
      if (m_boot) m_ip = m_ip + {28'h0, l};
      else begin
        low = m_ip[15:0] + {12'h0, l};
        m_ip = {16'h0, low};
      end
    end
    @(posedge clk);
    @(negedge clk);
    adv_en = 0; near_en = 0; far_en = 0; int_en = 0;
    @(posedge clk);
    @(negedge clk);
    check(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset vector
    do_reset("R1");
    // R9: idle cycles hold state
    step(0, 4'd0, 0, 16'h0, 0, 16'h0, 16'h0, 0, 16'h0, 16'h0, "R9");
    // R7: boot-window advance, full 32-bit add crosses 0xFFFF
    for (int l = 0; l < 16; l++)
      step(1, 4'(l), 0, 16'h0, 0, 16'h0, 16'h0, 0, 16'h0, 16'h0, "R7");
    // R3: near jumps keep elevated base
    for (int k = 0; k < 16; k++)
      step(0, 4'd0, 1, 16'(k * 16'h1111 + 16'h0003), 0, 16'h0, 16'h0, 0, 16'h0, 16'h0, "R3");
    // R4/R6: far jump sweep
    for (int k = 0; k < 16; k++)
      step(0, 4'd0, 0, 16'h0, 1, 16'(k * 16'h1001), 16'(16'hFFF8 - k), 0, 16'h0, 16'h0, "R4");
    step(0, 4'd0, 0, 16'h0, 0, 16'h0, 16'h0, 0, 16'h0, 16'h0, "R6");
    // R7: 16-bit wrap after reload
    for (int l = 0; l < 16; l++)
      step(1, 4'(l), 0, 16'h0, 0, 16'h0, 16'h0, 0, 16'h0, 16'h0, "R7");
    // R5: interrupt entry sweep, from reset each time
    for (int k = 0; k < 8; k++) begin
      do_reset("R1");
      step(0, 4'd0, 0, 16'h0, 0, 16'h0, 16'h0, 1, 16'(16'hF000 + k * 16'h0123), 16'(k * 16'h2222), "R5");
      step(1, 4'hF, 0, 16'h0, 0, 16'h0, 16'h0, 0, 16'h0, 16'h0, "R6");
    end
    // R8: every combination of simultaneous requests
    for (int m = 1; m < 16; m++) begin
      do_reset("R1");
      step(m[0], 4'h9, m[1], 16'h1234, m[2], 16'h0ABC, 16'h0040, m[3], 16'h7000, 16'h0010, "R8");
    end
    // R8: reset outranks everything
    @(negedge clk);
    int_en = 1; far_en = 1; near_en = 1; adv_en = 1; rst = 1;
    @(posedge clk);
    @(negedge clk);
    rst = 0; int_en = 0; far_en = 0; near_en = 0; adv_en = 0;
    m_sel = 16'hF000; m_base = 32'hFFFF0000; m_ip = 32'h0000FFF0; m_boot = 1'b1;
    check("R8");
    // R2: a run of mixed commands
    for (int k = 0; k < 32; k++)
      step(1, 4'(k), (k % 5) == 2, 16'(k * 16'h0777), (k % 11) == 7, 16'(k * 16'h0101), 16'hFFFE, 0, 16'h0, 16'h0, "R2");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule